// File: doc/BRIEF.md
# Checkerboard-Clocked Lookup Cell Grid

This block is a rectangular array of identical four-in, four-out logic cells. Each cell holds four small truth tables, one for each of its outputs, and each table is addressed by the cell's four input bits. A cell sees only the outputs of the four cells next to it, and it drives only those same four neighbours. No switchable routing and no wire longer than one cell pitch exist anywhere in the grid. Cells on the array's edges take their outward-facing inputs from boundary input ports, and their outward-facing outputs appear on boundary output ports.

The cell registers update on two alternating phases in a checkerboard pattern. On one phase the "even" cells update, and on the next phase the "odd" cells update. A cell therefore always samples neighbours that are holding still. A value moving across the grid advances exactly one cell per phase, so the latency of any mapped function is the length of its path in cells. The truth tables are written through one serial shift chain that runs through every cell. While that chain is shifting, the data path is frozen.

Top module: `lut_grid`

## Requirements
- R1: While `rst_n` is low, every cell output register is zero, so all boundary outputs read 0, and `phase_b` is 0 (phase A).
- R2: While `cfg_en` is high, the configuration chain moves one bit per clock. `cfg_din` enters bit 0 of cell (0,0). Bit 63 of cell k (row-major, k = row*COLS+col) feeds bit 0 of cell k+1. `cfg_dout` is bit 63 of the last cell. A bit therefore appears on `cfg_dout` 64*ROWS*COLS shifts after it entered.
- R3: While `cfg_en` is high, all cell output registers and `phase_b` keep their values.
- R4: Cell configuration word bits [16*d+15:16*d] form the table for output direction d, where N=3, E=2, S=1 and W=0. The table is indexed by {n,e,s,w}, with the north input as the most significant bit.
- R5: A cell's north input is the south output of the cell above it, its east input is the west output of the cell to its right, its south input is the north output of the cell below it, and its west input is the east output of the cell to its left.
- R6: At the edges, bit c of `north_in`/`south_in` feeds column c of the top/bottom row, and bit r of `west_in`/`east_in` feeds row r of the left/right column. The facing outputs of those same cells drive `north_out`, `south_out`, `west_out` and `east_out`.
- R7: With `cfg_en` low, `phase_b` toggles on every clock. On a clock where `phase_b` is 0, only cells with even row+column load their table outputs. On a clock where it is 1, only the odd cells load.
- R8: If the west-to-east pass-through table (E table = 16'hAAAA, others 0) is loaded in every cell and `west_in[0]` changes just before a phase-A clock, `east_out[0]` changes exactly COLS clocks later and not earlier.
- R9: Reset leaves every table intact, so after reset is released the grid computes with the tables it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_en | input | 1 | Configuration shift enable; freezes the data path |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (end of chain) |
| north_in | input | COLS | External inputs to the top row |
| south_in | input | COLS | External inputs to the bottom row |
| west_in | input | ROWS | External inputs to the left column |
| east_in | input | ROWS | External inputs to the right column |
| north_out | output | COLS | North outputs of the top row |
| south_out | output | COLS | South outputs of the bottom row |
| west_out | output | ROWS | West outputs of the left column |
| east_out | output | ROWS | East outputs of the right column |
| phase_b | output | 1 | Current phase: 0 = even cells update next, 1 = odd cells update next |

## Verification
The hold and phase properties assume that `cfg_en` is a clean synchronous level. They also assume that reset is never released while `cfg_en` is low and the tables are still unwritten. Otherwise the cells would load undefined table bits on the first clock. The stimulus holds `cfg_en` low during the first reset and raises it on the same falling edge that releases reset. A complete table load follows before any free-running clock. Later resets come only after valid tables are in place, and configuration bursts during operation are short, whole-clock pulses.

// File: rtl/lut_grid_pkg.sv
package lut_grid_pkg;

  localparam int NDIR          = 4;
  localparam int TBL_BITS      = 1 << NDIR;
  localparam int CELL_CFG_BITS = NDIR * TBL_BITS;

  // bit positions in a cell's output / input nibble and table slot order
  localparam int D_W = 0;
  localparam int D_S = 1;
  localparam int D_E = 2;
  localparam int D_N = 3;

  typedef logic [NDIR-1:0] nib_t;

  function automatic bit is_odd_cell(input int r, input int c);
    return ((r + c) % 2) == 1;
  endfunction

endpackage

// File: rtl/lut_phase_ctrl.sv
module lut_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  output logic phase_b
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!cfg_en) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign phase_b = phase_q;

endmodule

// File: rtl/lut_cell_table.sv
module lut_cell_table
  import lut_grid_pkg::*;
(
  input  logic clk,
  input  logic shift_en,
  input  logic ser_in,
  output logic ser_out,
  input  nib_t idx,
  output nib_t look
);

  logic [CELL_CFG_BITS-1:0] tbl_q;
  logic [CELL_CFG_BITS-1:0] tbl_d;

  always_comb begin
    tbl_d = tbl_q;
    if (shift_en) tbl_d = {tbl_q[CELL_CFG_BITS-2:0], ser_in};
  end

  // table storage carries no reset: contents survive a reset
  always_ff @(posedge clk) begin
    tbl_q <= tbl_d;
  end

  assign ser_out = tbl_q[CELL_CFG_BITS-1];

  for (genvar d = 0; d < NDIR; d++) begin : g_slot
    logic [TBL_BITS-1:0] slot;
    assign slot    = tbl_q[d*TBL_BITS +: TBL_BITS];
    assign look[d] = slot[idx];
  end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_grid_pkg::*;
#(
  parameter bit ODD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic phase_b,
  input  logic ser_in,
  output logic ser_out,
  input  nib_t nbr_in,
  output nib_t out_q
);

  nib_t look;
  nib_t out_r;
  nib_t out_d;
  logic upd_en;

  lut_cell_table u_tbl (
    .clk      (clk),
    .shift_en (cfg_en),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .idx      (nbr_in),
    .look     (look)
  );

  assign upd_en = !cfg_en && (phase_b == ODD);

  always_comb begin
    out_d = out_r;
    if (upd_en) out_d = look;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_r <= '0;
    else        out_r <= out_d;
  end

  assign out_q = out_r;

endmodule

// File: rtl/lut_grid.sv
module lut_grid
  import lut_grid_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic            cfg_dout,
  input  logic [COLS-1:0] north_in,
  input  logic [COLS-1:0] south_in,
  input  logic [ROWS-1:0] west_in,
  input  logic [ROWS-1:0] east_in,
  output logic [COLS-1:0] north_out,
  output logic [COLS-1:0] south_out,
  output logic [ROWS-1:0] west_out,
  output logic [ROWS-1:0] east_out,
  output logic            phase_b
);

  localparam int NCELL = ROWS * COLS;

  nib_t                   cq [ROWS][COLS];
  logic [NCELL:0]         chain;
  logic [NDIR*NCELL-1:0]  cell_q_flat;

  lut_phase_ctrl u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .phase_b (phase_b)
  );

  assign chain[0] = cfg_din;
  assign cfg_dout = chain[NCELL];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      logic n_i, e_i, s_i, w_i;

      if (r == 0)        begin : g_nb assign n_i = north_in[c];          end
      else               begin : g_ni assign n_i = cq[r-1][c][D_S];      end
      if (r == ROWS - 1) begin : g_sb assign s_i = south_in[c];          end
      else               begin : g_si assign s_i = cq[r+1][c][D_N];      end
      if (c == 0)        begin : g_wb assign w_i = west_in[r];           end
      else               begin : g_wi assign w_i = cq[r][c-1][D_E];      end
      if (c == COLS - 1) begin : g_eb assign e_i = east_in[r];           end
      else               begin : g_ei assign e_i = cq[r][c+1][D_W];      end

      lut_cell #(.ODD(is_odd_cell(r, c))) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .phase_b (phase_b),
        .ser_in  (chain[K]),
        .ser_out (chain[K+1]),
        .nbr_in  ({n_i, e_i, s_i, w_i}),
        .out_q   (cq[r][c])
      );

      assign cell_q_flat[NDIR*K +: NDIR] = cq[r][c];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_ns_edge
    assign north_out[c] = cq[0][c][D_N];
    assign south_out[c] = cq[ROWS-1][c][D_S];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_we_edge
    assign west_out[r] = cq[r][0][D_W];
    assign east_out[r] = cq[r][COLS-1][D_E];
  end

endmodule

// File: rtl/lut_grid_chk.sv
module lut_grid_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_en,
  input logic                    phase_b,
  input logic [4*ROWS*COLS-1:0]  cell_q_flat,
  input logic [COLS-1:0]         north_out,
  input logic [COLS-1:0]         south_out,
  input logic [ROWS-1:0]         west_out,
  input logic [ROWS-1:0]         east_out
);

  localparam int NB = 4 * ROWS * COLS;

  function automatic logic [NB-1:0] parity_mask(input bit want_odd);
    logic [NB-1:0] m;
    m = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if ((((r + c) % 2) == 1) == want_odd) m[4*(r*COLS+c) +: 4] = 4'hF;
    return m;
  endfunction

  localparam logic [NB-1:0] ODD_M  = parity_mask(1'b1);
  localparam logic [NB-1:0] EVEN_M = parity_mask(1'b0);

  a_r3_edges_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable({north_out, south_out, west_out, east_out}));

  a_r3_cells_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(cell_q_flat));

  a_r3_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(phase_b));

  a_r7_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (phase_b != $past(phase_b)));

  a_r7_odd_idle_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !phase_b) |=> $stable(cell_q_flat & ODD_M));

  a_r7_even_idle_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && phase_b) |=> $stable(cell_q_flat & EVEN_M));

endmodule

bind lut_grid lut_grid_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/lut_grid_bench.sv
module lut_grid_bench;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int NCELL = ROWS * COLS;
  localparam int TOT   = NCELL * 64;

  logic clk = 1'b0;
  logic rst_n, cfg_en, cfg_din;
  logic cfg_dout, phase_b;
  logic [COLS-1:0] north_in, south_in, north_out, south_out;
  logic [ROWS-1:0] west_in, east_in, west_out, east_out;

  always #2 clk = ~clk;

  lut_grid #(.ROWS(ROWS), .COLS(COLS)) u_lut_grid (
    .clk, .rst_n, .cfg_en, .cfg_din, .cfg_dout,
    .north_in, .south_in, .west_in, .east_in,
    .north_out, .south_out, .west_out, .east_out, .phase_b
  );

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference ----------------
  bit       chain_q[$];
  bit [3:0] om [ROWS][COLS];   // {N,E,S,W}
  bit       ph_m;
  int       shifts;

  function automatic bit tbl_bit(int r, int c, int d, bit [3:0] idx);
    return chain_q[64*(r*COLS+c) + 16*d + idx];
  endfunction

  initial begin
    for (int i = 0; i < TOT; i++) chain_q.push_back(1'b0);
    shifts = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) om[r][c] = 4'h0;
      ph_m = 1'b0;
    end else if (cfg_en) begin
      chain_q.push_front(cfg_din);
      void'(chain_q.pop_back());
      shifts++;
    end else begin
      bit [3:0] nx [ROWS][COLS];
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          bit n, e, s, w;
          n = (r == 0)      ? north_in[c] : om[r-1][c][1];
          s = (r == ROWS-1) ? south_in[c] : om[r+1][c][3];
          w = (c == 0)      ? west_in[r]  : om[r][c-1][2];
          e = (c == COLS-1) ? east_in[r]  : om[r][c+1][0];
          nx[r][c] = om[r][c];
          if (((r + c) % 2) == int'(ph_m))
            for (int d = 0; d < 4; d++) nx[r][c][d] = tbl_bit(r, c, d, {n, e, s, w});
        end
      om = nx;
      ph_m = !ph_m;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [COLS-1:0] en, es;
    logic [ROWS-1:0] ew, ee;
    for (int c = 0; c < COLS; c++) begin
      en[c] = om[0][c][3];
      es[c] = om[ROWS-1][c][1];
    end
    for (int r = 0; r < ROWS; r++) begin
      ew[r] = om[r][0][0];
      ee[r] = om[r][COLS-1][2];
    end
    chk(cur_req, "north_out", 32'(north_out), 32'(en));
    chk(cur_req, "south_out", 32'(south_out), 32'(es));
    chk(cur_req, "west_out",  32'(west_out),  32'(ew));
    chk(cur_req, "east_out",  32'(east_out),  32'(ee));
    chk(cur_req, "phase_b",   32'(phase_b),   32'(ph_m));
    if (shifts >= TOT) chk("R2", "cfg_dout", 32'(cfg_dout), 32'(chain_q[TOT-1]));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic load(input bit [63:0] words [NCELL]);
    cfg_en = 1'b1;
    for (int k = NCELL - 1; k >= 0; k--)
      for (int b = 63; b >= 0; b--) begin
        cfg_din = words[k][b];
        tick();
      end
    cfg_en = 1'b0;
  endtask

  task automatic rand_inputs();
    north_in = COLS'($urandom);
    south_in = COLS'($urandom);
    west_in  = ROWS'($urandom);
    east_in  = ROWS'($urandom);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [63:0] words [NCELL];
    logic [COLS-1:0] hn;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0;
    north_in = '0; south_in = '0; west_in = '0; east_in = '0;

    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    chk("R1", "edges zero in reset", 32'({north_out, south_out, west_out, east_out}), 32'h0);
    chk("R1", "phase A in reset", 32'(phase_b), 32'h0);
    rst_n = 1'b1;
    cfg_en = 1'b1;

    // R2: load west-to-east pass-through everywhere (R4: E table at bits 47:32)
    cur_req = "R2";
    for (int k = 0; k < NCELL; k++) words[k] = {16'h0000, 16'hAAAA, 16'h0000, 16'h0000};
    load(words);

    // R8: deterministic latency of COLS phases along row 0
    cur_req = "R8";
    tick();
    while (phase_b !== 1'b0) tick();
    west_in[0] = 1'b1;
    for (int i = 1; i <= COLS; i++) begin
      tick();
      chk("R8", $sformatf("east_out[0] after %0d clocks", i), 32'(east_out[0]),
          (i < COLS) ? 32'h0 : 32'h1);
    end

    // R5/R6: random boundary stimulus through pass-through grid
    cur_req = "R5";
    for (int i = 0; i < 60; i++) begin rand_inputs(); tick(); end
    cur_req = "R6";
    for (int i = 0; i < 60; i++) begin rand_inputs(); tick(); end

    // R2/R3: reload random tables while outputs are non-zero; dout carries first load
    cur_req = "R3";
    hn = north_out;
    for (int k = 0; k < NCELL; k++) words[k] = {$urandom, $urandom};
    load(words);
    chk("R3", "north_out held over load", 32'(north_out), 32'(hn));

    // R4/R7: random tables, random inputs, occasional short config bursts
    cur_req = "R4";
    for (int i = 0; i < 300; i++) begin
      rand_inputs();
      if (i % 37 == 36) begin
        cur_req = "R3";
        cfg_en = 1'b1; cfg_din = 1'($urandom);
        tick(); tick();
        cfg_en = 1'b0;
        cur_req = (i > 150) ? "R7" : "R4";
      end
      tick();
    end

    // R9: reset mid-run, tables survive
    cur_req = "R1";
    rst_n = 1'b0;
    tick();
    chk("R1", "edges cleared by reset", 32'({north_out, south_out, west_out, east_out}), 32'h0);
    rst_n = 1'b1;
    cur_req = "R9";
    for (int i = 0; i < 200; i++) begin rand_inputs(); tick(); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule